// File: doc/BRIEF.md
# Interleaved Modular Multiplier

This block computes `result = X * Y mod M` for unsigned operands `N` bits wide. It does not form the full double-width product. It walks the multiplier `X` one bit per iteration, starting at the most significant bit. In each iteration it doubles a running partial value, adds `Y` when the current bit of `X` is one, and then reduces the sum against `M` with two trial subtractions, applied one after the other. Each iteration has to end before the next one starts, because every trial subtraction needs the complete result of the step before it.

There is no full-width carry chain. Every wide add and every trial subtraction runs on one adder slice `W` bits wide, which the block reuses over several clock cycles while the carry passes from one segment to the next. The internal partial value spans `N + W` bits, in `SEGS = N/W + 1` segments, so `2*P + Y` always fits before reduction. The caller pulses `start` with `X`, `Y` and `M` on the inputs and waits for `done`. The caller must keep `X < M` and `Y < M`, and `N` must be a multiple of `W`, with `W >= 2`.

Top module: `modmul_interleaved`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled high on a clock edge while `busy` is 0 captures `x_in`, `y_in` and `m_in` at that edge and raises `busy` at that same edge.
- R3: For operands with `X < M` and `Y < M`, the value of `result` when `done` is high equals `(X*Y) mod M`, including the cases X = 0, Y = 0 and M = 1.
- R4: The sum `2*P + Y` of an iteration never carries out of the internal `N + W` bit partial value, even for X = Y = M - 1 with M = 2^N - 1.
- R5: A trial subtraction is applied whenever the partial value is greater than or equal to M, so a product that is an exact multiple of M gives `result` = 0 and `result` is always below M.
- R6: After both trial subtractions of an iteration, the partial value is below M.
- R7: `done` goes high exactly `3*SEGS*N` clock edges after the edge that accepted `start`. `busy` stays high from the accepting edge up to, but not including, that edge.
- R8: `done` is high for exactly one cycle per operation, and `busy` is low while it is high.
- R9: A `start` sampled while `busy` is 1 is ignored. The running operation keeps its operands and its timing.
- R10: `result` keeps its value from one completion until the next, whatever happens on `x_in`, `y_in`, `m_in` and `start` in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (only acted on while idle) |
| x_in | input | N | Multiplier X, scanned from the MSB |
| y_in | input | N | Multiplicand Y |
| m_in | input | N | Modulus M, non-zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | N | Last completed X*Y mod M |

## Verification
The bench keeps a cycle-accurate behavioural model: a busy flag, an edge counter and an expected product from wide integer arithmetic. The model updates on the same rising edges as the design. `busy` must rise on the edge that accepts `start` and fall `3*SEGS*N` edges later, on the edge where `done` rises and `result` takes its new value. The design's three outputs are compared with the model on every falling edge, half a period after the registers change. Any cycle of early or late timing therefore shows up as a mismatch. Operand and start changes are driven on falling edges only, so the model and the design sample them at the same rising edge.

// File: rtl/modmul_pkg.sv
package modmul_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADD  = 2'd1,
        PH_RED1 = 2'd2,
        PH_RED2 = 2'd3
    } phase_e;

endpackage

// File: rtl/modmul_seg_adder.sv
module modmul_seg_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] total;

    always_comb begin
        total  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = total[W-1:0];
        cout_o = total[W];
    end
endmodule

// File: rtl/modmul_sequencer.sv
module modmul_sequencer
    import modmul_pkg::*;
#(
    parameter int N    = 32,
    parameter int SEGS = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase_o,
    output logic   load_o,
    output logic   seg_last_o,
    output logic   bit_last_o
);
    localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1;
    localparam int BIT_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [SEG_W-1:0] seg;
        logic [BIT_W-1:0] bitn;
    } seq_t;

    seq_t s_d, s_q;
    logic busy_w;

    always_comb begin
        busy_w     = (s_q.phase != PH_IDLE);
        load_o     = start && !busy_w;
        seg_last_o = (s_q.seg == SEG_W'(SEGS - 1));
        bit_last_o = (s_q.bitn == '0);
        phase_o    = s_q.phase;

        s_d = s_q;
        if (load_o) begin
            s_d.phase = PH_ADD;
            s_d.seg   = '0;
            s_d.bitn  = BIT_W'(N - 1);
        end else if (busy_w) begin
            if (seg_last_o) begin
                s_d.seg = '0;
                unique case (s_q.phase)
                    PH_ADD:  s_d.phase = PH_RED1;
                    PH_RED1: s_d.phase = PH_RED2;
                    PH_RED2: begin
                        if (bit_last_o) begin
                            s_d.phase = PH_IDLE;
                        end else begin
                            s_d.phase = PH_ADD;
                            s_d.bitn  = s_q.bitn - 1'b1;
                        end
                    end
                    default: s_d.phase = PH_IDLE;
                endcase
            end else begin
                s_d.seg = s_q.seg + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, seg: '0, bitn: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |-> (s_q.seg < SEG_W'(SEGS))); // R7
    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.phase != PH_IDLE) |-> (s_q.phase == PH_ADD && s_q.seg == '0
                                         && s_q.bitn == BIT_W'(N - 1))); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && !(s_q.phase == PH_RED2 && seg_last_o && bit_last_o))
        |=> (s_q.phase != PH_IDLE)); // R9
endmodule

// File: rtl/modmul_interleaved.sv
module modmul_interleaved
    import modmul_pkg::*;
#(
    parameter int N = 32,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    input  logic [N-1:0] m_in,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int SEGS = N / W + 1;
    localparam int DW   = SEGS * W;

    typedef struct packed {
        logic [DW-1:0] part;
        logic [DW-1:0] acc;
        logic [DW-1:0] opb;
        logic          cy;
        logic [N-1:0]  xs;
        logic [N-1:0]  ys;
        logic [N-1:0]  ms;
        logic [N-1:0]  res;
        logic          done;
    } dp_t;

    dp_t d_d, d_q;

    phase_e        phase;
    logic          load, seg_last, bit_last;
    logic [W-1:0]  seg_sum;
    logic          seg_cout;
    logic [DW-1:0] shifted;
    logic [DW-1:0] kept;
    logic [DW-1:0] neg_m;

    modmul_sequencer #(.N(N), .SEGS(SEGS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase_o    (phase),
        .load_o     (load),
        .seg_last_o (seg_last),
        .bit_last_o (bit_last)
    );

    modmul_seg_adder #(.W(W)) u_add (
        .a_i    (d_q.acc[W-1:0]),
        .b_i    (d_q.opb[W-1:0]),
        .cin_i  (d_q.cy),
        .sum_o  (seg_sum),
        .cout_o (seg_cout)
    );

    always_comb begin
        shifted = {seg_sum, d_q.acc[DW-1:W]};
        kept    = seg_cout ? shifted : d_q.part;
        neg_m   = ~{{W{1'b0}}, d_q.ms};

        d_d      = d_q;
        d_d.done = 1'b0;
        if (load) begin
            d_d.part = '0;
            d_d.acc  = '0;
            d_d.opb  = x_in[N-1] ? {{W{1'b0}}, y_in} : '0;
            d_d.cy   = 1'b0;
            d_d.xs   = x_in << 1;
            d_d.ys   = y_in;
            d_d.ms   = m_in;
        end else if (phase != PH_IDLE) begin
            d_d.acc = shifted;
            d_d.opb = d_q.opb >> W;
            d_d.cy  = seg_cout;
            if (seg_last) begin
                unique case (phase)
                    PH_ADD: begin
                        d_d.part = shifted;
                        d_d.acc  = shifted;
                        d_d.opb  = neg_m;
                        d_d.cy   = 1'b1;
                    end
                    PH_RED1: begin
                        d_d.part = kept;
                        d_d.acc  = kept;
                        d_d.opb  = neg_m;
                        d_d.cy   = 1'b1;
                    end
                    PH_RED2: begin
                        d_d.part = kept;
                        if (bit_last) begin
                            d_d.res  = kept[N-1:0];
                            d_d.done = 1'b1;
                        end else begin
                            d_d.acc = kept << 1;
                            d_d.opb = d_q.xs[N-1] ? {{W{1'b0}}, d_q.ys} : '0;
                            d_d.cy  = 1'b0;
                            d_d.xs  = d_q.xs << 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign busy   = (phase != PH_IDLE);
    assign done   = d_q.done;
    assign result = d_q.res;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADD && seg_last) |-> !seg_cout); // R4
    AST_ITER_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RED2 && seg_last) |=> (d_q.part < {{W{1'b0}}, d_q.ms})); // R6
    AST_RESULT_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < d_q.ms)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R10
endmodule

// File: tb/sim_modmul_interleaved.sv
`timescale 1ns/1ps
module sim_modmul_interleaved;
    localparam int N    = 32;
    localparam int W    = 8;
    localparam int SEGS = N / W + 1;
    localparam int LAT  = 3 * SEGS * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic         busy, done;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic         m_busy = 1'b0, m_done = 1'b0;
    logic [N-1:0] m_res = '0, m_exp = '0;
    int           m_cnt = 0;

    always #2 clk = ~clk;

    modmul_interleaved #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [N-1:0] ref_mod(input logic [N-1:0] a, b, m);
        logic [2*N-1:0] prod;
        prod = {{N{1'b0}}, a} * {{N{1'b0}}, b};
        return N'(prod % {{N{1'b0}}, m});
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_res <= '0; m_cnt <= 0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                m_busy <= 1'b1;
                m_cnt  <= 0;
                m_exp  <= ref_mod(x_in, y_in, m_in);
            end else if (m_busy) begin
                if (m_cnt == LAT - 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_exp;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [N-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the model, half a period after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R7 busy", N'(busy), N'(m_busy));
            check("R8 done", N'(done), N'(m_done));
            check("R3/R10 result", result, m_res);
        end
    end

    task automatic pulse_start(input logic [N-1:0] x, y, m);
        @(negedge clk);
        x_in = x; y_in = y; m_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [N-1:0] x, y, m, input string req);
        pulse_start(x, y, m);
        repeat (LAT + 2) @(negedge clk);
        check(req, result, ref_mod(x, y, m));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check("R1 busy", N'(busy), '0);
        check("R1 done", N'(done), '0);
        check("R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after release", result, '0);

        run_op(32'd3, 32'd5, 32'd7, "R3 small");
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4 max operands");
        run_op(32'hFFFF_FFFA, 32'hFFFF_FFF0, 32'hFFFF_FFFB, "R4 near max");
        run_op(32'd0, 32'd0, 32'd1, "R3 M=1");
        run_op(32'd0, 32'h1234, 32'h8000_0001, "R3 X=0");
        run_op(32'h7654, 32'd0, 32'h8000_0001, "R3 Y=0");
        run_op(32'd2, 32'd500, 32'd1000, "R5 exact multiple");
        run_op(32'd4, 32'h4000_0000, 32'h8000_0000, "R5 equal boundary");

        // R9: start while busy is ignored
        pulse_start(32'h0BAD_CAFE, 32'h1357_9BDF, 32'hF00D_F00D);
        repeat (100) @(negedge clk);
        x_in = 32'd1; y_in = 32'd1; m_in = 32'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
        check("R9 ignored start", result, ref_mod(32'h0BAD_CAFE, 32'h1357_9BDF, 32'hF00D_F00D));

        // R10: inputs change without start, result must hold
        x_in = 32'hFFFF_0000; y_in = 32'h0000_FFFF; m_in = 32'h1234_5679;
        repeat (40) @(negedge clk);
        check("R10 hold", result, ref_mod(32'h0BAD_CAFE, 32'h1357_9BDF, 32'hF00D_F00D));

        for (int i = 0; i < 16; i++) begin
            logic [N-1:0] m, x, y;
            m = N'($urandom);
            if (m == '0) m = 1;
            x = N'($urandom) % m;
            y = N'($urandom) % m;
            run_op(x, y, m, "R3 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule